// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that sits behind a byte-wide register port. It can count one of two sources. The first is a free-running internal tick, one pulse every four system clocks. The second is the rising edges of an external clock pin. The chosen source passes through a power-of-two prescaler before it reaches the counter. A run bit gates counting. A trigger from a compare unit forces the count to zero. When the count wraps from all ones to zero, a sticky overflow flag is raised for interrupt logic.

The external pin can take one of two paths. The synchronized path goes through a two-stage synchronizer and then edge detection. The direct path is edge-detected straight from the pin, so it reacts two clocks sooner. In wide mode, software can move all sixteen bits as a single unit over the eight-bit port. Reading the low byte captures the live high byte into a holding register, and a later high-byte read returns that captured value. A high-byte write only fills the holding register; the following low-byte write loads both bytes into the counter on the same clock. When wide mode is off, the high byte is read and written directly.

The register port is a plain per-cycle strobe interface with no back-pressure. The block accepts every access in the cycle it is presented. Read data is combinational from the current state and the byte select. If a write and a read are strobed together, the write is performed and the read's side effect is dropped.

Top module: `pscl_timer16`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0, and the wide-mode holding register is 0x00.
- R2: With `cfg_ext_sel`=0, `cfg_ps`=0 and `cfg_run`=1, the count rises by exactly one for every four clock edges. Over any 40 consecutive edges it rises by 10.
- R3: With `cfg_ext_sel`=1, the count rises by one for each rising edge of `ext_clk_in`. Falling edges and steady levels do not change it.
- R4: A `cfg_ps` code k divides the selected source by 2^k (k = 0..3 gives 1, 2, 4, 8). After a count write, N source events give floor(N / 2^k) increments.
- R5: With `cfg_sync`=0, a rise of `ext_clk_in` that is present at a clock edge shows in the count after that edge. With `cfg_sync`=1, it shows after the third edge, which is two clocks later.
- R6: While `cfg_run`=0, source events are discarded and the count holds.
- R7: `evt_clear`=1 sets the count to zero at the next edge. It takes priority over increments and writes, and it never sets the overflow flag.
- R8: An increment from 0xFFFF gives 0x0000 and sets `ovf_flag`. The flag stays set until `flag_clr` is pulsed. If a new overflow and `flag_clr` fall in the same cycle, the flag stays set.
- R9: With `cfg_wide`=1, a low-byte read (`bus_hi`=0 with `bus_rd`) copies the live high byte into the holding register. A high-byte read returns the holding register.
- R10: With `cfg_wide`=1, a high-byte write (`bus_hi`=1) changes only the holding register. A low-byte write loads {holding, wdata} into the counter in one edge.
- R11: With `cfg_wide`=0, high-byte reads and writes act on the live counter high byte, and reads leave the holding register untouched.
- R12: Any write that changes the count, and any `evt_clear`, restarts the prescaler. The first increment afterwards needs a full 2^k source events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | 1 lets the counter advance |
| cfg_ext_sel | input | 1 | 0 selects the internal tick, 1 selects the external pin |
| cfg_sync | input | 1 | 1 routes the external pin through the synchronizer |
| cfg_ps | input | 2 | Prescale code k, divide by 2^k |
| cfg_wide | input | 1 | 1 enables buffered 16-bit access |
| ext_clk_in | input | 1 | External count input |
| evt_clear | input | 1 | Compare-match trigger that zeroes the count |
| flag_clr | input | 1 | Clears the overflow flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (its only effect is the wide-mode capture) |
| bus_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected byte |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
Any wrong internal state shows up at the read port. A prescaler that drifts or a lost or duplicated source event makes the low byte differ from the reference count at the first edge where an increment lands early or late, which is at most eight source events later. A corrupted holding register shows only on the next wide-mode high-byte read, or on the low-byte write that loads it. The bench compares the read data and the flag on every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/pscl_timer16_pkg.sv
package pscl_timer16_pkg;

  // Decoded register-port action for one cycle.
  typedef struct packed {
    logic zero;        // compare trigger
    logic load_lo;     // live low byte (narrow mode)
    logic load_hi;     // live high byte (narrow mode)
    logic load_both;   // {holding, wdata} (wide mode)
    logic fill_buf;    // holding <= wdata (wide mode)
    logic snap_buf;    // holding <= live high byte (wide mode)
  } tmr_op_t;

  function automatic logic op_restarts(input tmr_op_t op);
    return op.zero | op.load_lo | op.load_hi | op.load_both;
  endfunction

endpackage

// File: rtl/pscl_timer16_src.sv
module pscl_timer16_src #(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic sync_en,
  input  logic ext_in,
  output logic src_tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]       div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_prev_q;
  logic                   int_tick;
  logic                   rise_sync;
  logic                   rise_raw;

  // free-running instruction-cycle divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + DIV_W'(1);
  end
  assign int_tick = (div_q == DIV_LAST);

  // synchronizer chain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev_q <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      sync_prev_q <= sync_q[SYNC_STAGES-1];
      raw_prev_q  <= ext_in;
    end
  end

  assign rise_sync = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
  assign rise_raw  = ext_in & ~raw_prev_q;

  always_comb begin
    if (!ext_sel)     src_tick = int_tick;
    else if (sync_en) src_tick = rise_sync;
    else              src_tick = rise_raw;
  end
endmodule

// File: rtl/pscl_timer16_prescale.sv
module pscl_timer16_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_in,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps_sel,
  output logic            inc
);
  localparam int PC_W = ((1 << PS_W) - 1) > 0 ? ((1 << PS_W) - 1) : 1;

  logic [PC_W-1:0] ps_q;
  logic [PC_W-1:0] ones_sh;
  logic [PC_W-1:0] last_v;
  logic            take;

  always_comb begin
    ones_sh = {PC_W{1'b1}} << ps_sel;
    last_v  = ~ones_sh;
  end

  assign take = run & tick_in;
  assign inc  = take & (ps_q >= last_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= '0;
    else if (restart) ps_q <= '0;
    else if (take)    ps_q <= inc ? '0 : ps_q + PC_W'(1);
  end
endmodule

// File: rtl/pscl_timer16_core.sv
module pscl_timer16_core
  import pscl_timer16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic                evt_clear,
  input  logic                wide,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_hi,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  logic                flag_clr,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic [BYTE_W-1:0]   rdata,
  output logic                ovf_flag,
  output logic                restart
);
  localparam int CNT_W = 2 * BYTE_W;

  tmr_op_t           op;
  logic [BYTE_W-1:0] hold_q;
  logic              wrap;

  always_comb begin
    op           = '0;
    op.zero      = evt_clear;
    op.load_lo   = bus_wr & ~bus_hi & ~wide;
    op.load_hi   = bus_wr &  bus_hi & ~wide;
    op.load_both = bus_wr & ~bus_hi &  wide;
    op.fill_buf  = bus_wr &  bus_hi &  wide;
    op.snap_buf  = ~bus_wr & bus_rd & ~bus_hi & wide;
  end

  assign restart = op_restarts(op);
  assign wrap    = inc & ~restart & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (op.zero)      cnt_q <= '0;
    else if (op.load_both) cnt_q <= {hold_q, bus_wdata};
    else if (op.load_lo)   cnt_q <= {cnt_q[CNT_W-1:BYTE_W], bus_wdata};
    else if (op.load_hi)   cnt_q <= {bus_wdata, cnt_q[BYTE_W-1:0]};
    else if (inc)          cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_q <= '0;
    else if (op.fill_buf) hold_q <= bus_wdata;
    else if (op.snap_buf) hold_q <= cnt_q[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
  end

  always_comb begin
    if (!bus_hi)   rdata = cnt_q[BYTE_W-1:0];
    else if (wide) rdata = hold_q;
    else           rdata = cnt_q[CNT_W-1:BYTE_W];
  end
endmodule

// File: rtl/pscl_timer16.sv
module pscl_timer16 #(
  parameter int BYTE_W      = 8,
  parameter int TICK_DIV    = 4,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_run,
  input  logic              cfg_ext_sel,
  input  logic              cfg_sync,
  input  logic [PS_W-1:0]   cfg_ps,
  input  logic              cfg_wide,
  input  logic              ext_clk_in,
  input  logic              evt_clear,
  input  logic              flag_clr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_hi,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             src_tick;
  logic             inc;
  logic             restart;
  logic [CNT_W-1:0] cnt_q;

  pscl_timer16_src #(
    .TICK_DIV   (TICK_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_sel (cfg_ext_sel),
    .sync_en (cfg_sync),
    .ext_in  (ext_clk_in),
    .src_tick(src_tick)
  );

  pscl_timer16_prescale #(
    .PS_W(PS_W)
  ) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_in(src_tick),
    .run    (cfg_run),
    .restart(restart),
    .ps_sel (cfg_ps),
    .inc    (inc)
  );

  pscl_timer16_core #(
    .BYTE_W(BYTE_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .evt_clear(evt_clear),
    .wide     (cfg_wide),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_hi   (bus_hi),
    .bus_wdata(bus_wdata),
    .flag_clr (flag_clr),
    .cnt_q    (cnt_q),
    .rdata    (bus_rdata),
    .ovf_flag (ovf_flag),
    .restart  (restart)
  );
endmodule

// File: rtl/pscl_timer16_chk.sv
module pscl_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_run,
  input logic             cfg_wide,
  input logic             evt_clear,
  input logic             flag_clr,
  input logic             bus_wr,
  input logic             bus_hi,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_flag
);
  logic cnt_write;
  assign cnt_write = bus_wr & (~bus_hi | ~cfg_wide);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (cnt_q == '0));

  // R7
  clear_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> !$rose(ovf_flag));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run && !evt_clear && !cnt_write) |=> $stable(cnt_q));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_clear && !cnt_write) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0));
endmodule

bind pscl_timer16 pscl_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_run  (cfg_run),
  .cfg_wide (cfg_wide),
  .evt_clear(evt_clear),
  .flag_clr (flag_clr),
  .bus_wr   (bus_wr),
  .bus_hi   (bus_hi),
  .cnt_q    (cnt_q),
  .ovf_flag (ovf_flag)
);

// File: tb/pscl_timer16_bench.sv
`timescale 1ns/1ps
module pscl_timer16_bench;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_run = 0, cfg_ext_sel = 0, cfg_sync = 0, cfg_wide = 0;
  logic [1:0] cfg_ps = 0;
  logic       ext_clk_in = 0, evt_clear = 0, flag_clr = 0;
  logic       bus_wr = 0, bus_rd = 0, bus_hi = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  // reference state
  int m_cnt, m_hold, m_ps, m_div;
  bit m_flag, m_prev, m_s1, m_s2, m_s3;

  always #10 clk = ~clk;

  pscl_timer16 u_pscl_timer16 (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_ext_sel(cfg_ext_sel),
    .cfg_sync(cfg_sync), .cfg_ps(cfg_ps), .cfg_wide(cfg_wide),
    .ext_clk_in(ext_clk_in), .evt_clear(evt_clear), .flag_clr(flag_clr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_hi(bus_hi), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_ps = 0; m_div = 0;
      m_flag = 0; m_prev = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      int  last, old;
      bit  tick, wr, rd, cwr, inc;
      last = (1 << cfg_ps) - 1;
      if (!cfg_ext_sel)  tick = (m_div == TDIV - 1);
      else if (cfg_sync) tick = m_s2 && !m_s3;
      else               tick = ext_clk_in && !m_prev;
      wr  = bus_wr;
      rd  = bus_rd && !bus_wr;
      cwr = wr && (!bus_hi || !cfg_wide);
      inc = cfg_run && tick && (m_ps >= last);
      old = m_cnt;
      if (evt_clear || cwr)     m_ps = 0;
      else if (cfg_run && tick) m_ps = inc ? 0 : m_ps + 1;
      if (evt_clear) m_cnt = 0;
      else if (cwr) begin
        if (!bus_hi && cfg_wide) m_cnt = m_hold * 256 + bus_wdata;
        else if (!bus_hi)        m_cnt = (old & 'hff00) | bus_wdata;
        else                     m_cnt = (bus_wdata << 8) | (old & 'hff);
      end else if (inc) m_cnt = (old + 1) & 'hffff;
      if (!evt_clear && !cwr && inc && old == 'hffff) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (wr && bus_hi && cfg_wide)      m_hold = bus_wdata;
      else if (rd && !bus_hi && cfg_wide) m_hold = old >> 8;
      m_div = (m_div + 1) % TDIV;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in; m_prev = ext_clk_in;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int exp_rd;
      if (!bus_hi)       exp_rd = m_cnt & 'hff;
      else if (cfg_wide) exp_rd = m_hold;
      else               exp_rd = m_cnt >> 8;
      chk(bus_rdata == exp_rd, cur_req, bus_rdata, exp_rd);
      chk(ovf_flag == m_flag, cur_req, ovf_flag, m_flag);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input bit hi, input int d);
    bus_wr = 1; bus_hi = hi; bus_wdata = d[7:0];
    cyc(1);
    bus_wr = 0; bus_hi = 0;
  endtask

  task automatic rd(input bit hi, output int v);
    bus_rd = 1; bus_hi = hi; #1; v = bus_rdata;
    cyc(1);
    bus_rd = 0; bus_hi = 0;
  endtask

  task automatic peek(input bit hi, output int v);
    bus_hi = hi; #1; v = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1; cyc(2);
      ext_clk_in = 0; cyc(2);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    cyc(3);
    rst_n = 1;
    cyc(1);
    cmp_on = 1;

    // R1 reset state
    cur_req = "R1";
    peek(0, v); chk(v == 0, "R1 low", v, 0);
    peek(1, v); chk(v == 0, "R1 high", v, 0);
    chk(ovf_flag == 0, "R1 flag", ovf_flag, 0);
    cfg_wide = 1; peek(1, v); chk(v == 0, "R1 hold", v, 0); cfg_wide = 0;

    // R2 internal tick, divide by 1
    cur_req = "R2";
    wr(0, 0);
    cfg_run = 1; cyc(40); cfg_run = 0;
    peek(0, v); chk(v == 10, "R2 forty edges", v, 10);

    // R4 prescale codes 1..3
    cur_req = "R4";
    cfg_ps = 1; wr(0, 0); cfg_run = 1; cyc(80); cfg_run = 0;
    peek(0, v); chk(v == 10, "R4 div2", v, 10);
    cfg_ps = 2; wr(0, 0); cfg_run = 1; cyc(160); cfg_run = 0;
    peek(0, v); chk(v == 10, "R4 div4", v, 10);
    cfg_ps = 3; wr(0, 0); cfg_run = 1; cyc(320); cfg_run = 0;
    peek(0, v); chk(v == 10, "R4 div8", v, 10);

    // R6 edges while stopped, then R3 edge counting
    cur_req = "R6";
    cfg_ps = 0; cfg_ext_sel = 1; cfg_sync = 0; wr(0, 0);
    pulse(3);
    peek(0, v); chk(v == 0, "R6 stopped", v, 0);
    cur_req = "R3";
    cfg_run = 1; pulse(7);
    peek(0, v); chk(v == 7, "R3 seven rises", v, 7);
    cyc(5);
    peek(0, v); chk(v == 7, "R3 steady level", v, 7);

    // R5 latency of both paths
    cur_req = "R5";
    wr(0, 0);
    ext_clk_in = 1; cyc(1);
    peek(0, v); chk(v == 1, "R5 direct one edge", v, 1);
    ext_clk_in = 0; cyc(4);
    cfg_sync = 1; cyc(4); wr(0, 0);
    ext_clk_in = 1; cyc(1);
    peek(0, v); chk(v == 0, "R5 sync edge1", v, 0);
    cyc(1);
    peek(0, v); chk(v == 0, "R5 sync edge2", v, 0);
    cyc(1);
    peek(0, v); chk(v == 1, "R5 sync edge3", v, 1);
    ext_clk_in = 0; cyc(4); cfg_sync = 0; cyc(2);

    // R12 prescaler restart on write
    cur_req = "R12";
    cfg_ps = 3; wr(0, 0);
    pulse(3);
    wr(0, 0);
    pulse(7);
    peek(0, v); chk(v == 0, "R12 seven after write", v, 0);
    pulse(1);
    peek(0, v); chk(v == 1, "R12 eighth", v, 1);

    // R7 clear priority
    cur_req = "R7";
    cfg_ps = 0; cfg_ext_sel = 0; wr(0, 'h40);
    cyc(10);
    evt_clear = 1; cyc(8);
    peek(0, v); chk(v == 0, "R7 held clear", v, 0);
    evt_clear = 0;
    cfg_run = 0;
    wr(1, 'hff); wr(0, 'hff);
    evt_clear = 1; cyc(1); evt_clear = 0;
    peek(1, v); chk(v == 0, "R7 clear from ffff", v, 0);
    chk(ovf_flag == 0, "R7 no flag", ovf_flag, 0);

    // R8 rollover flag
    cur_req = "R8";
    cfg_ext_sel = 1; cfg_run = 1;
    wr(1, 'hff); wr(0, 'hff);
    pulse(1);
    peek(0, v); chk(v == 0, "R8 wrap low", v, 0);
    chk(ovf_flag == 1, "R8 set", ovf_flag, 1);
    cyc(5);
    chk(ovf_flag == 1, "R8 sticky", ovf_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk(ovf_flag == 0, "R8 cleared", ovf_flag, 0);
    wr(1, 'hff); wr(0, 'hff); pulse(1);
    wr(1, 'hff); wr(0, 'hff);
    ext_clk_in = 1; flag_clr = 1; cyc(1); flag_clr = 0;
    chk(ovf_flag == 1, "R8 set beats clear", ovf_flag, 1);
    ext_clk_in = 0; cyc(2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    cfg_run = 0; cfg_ext_sel = 0;

    // R10 wide writes
    cur_req = "R10";
    wr(1, 0); wr(0, 'h34);
    cfg_wide = 1; wr(1, 'h12);
    cfg_wide = 0; peek(1, v); chk(v == 0, "R10 high write buffered only", v, 0);
    cfg_wide = 1; wr(0, 'h56);
    cfg_wide = 0;
    peek(1, v); chk(v == 'h12, "R10 joint load high", v, 'h12);
    peek(0, v); chk(v == 'h56, "R10 joint load low", v, 'h56);

    // R9 wide reads
    cur_req = "R9";
    cfg_wide = 1; wr(1, 'h77);
    rd(1, v); chk(v == 'h77, "R9 high from holding", v, 'h77);
    rd(0, v); chk(v == 'h56, "R9 low read", v, 'h56);
    rd(1, v); chk(v == 'h12, "R9 captured high", v, 'h12);

    // R11 narrow mode direct high byte
    cur_req = "R11";
    cfg_wide = 0; wr(1, 'ha5);
    peek(1, v); chk(v == 'ha5, "R11 direct high", v, 'ha5);
    peek(0, v); chk(v == 'h56, "R11 low kept", v, 'h56);
    rd(0, v);
    cfg_wide = 1; peek(1, v); chk(v == 'h12, "R11 holding untouched", v, 'h12);
    cfg_wide = 0;

    cyc(3);
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule